// File: doc/BRIEF.md
# PWM Timer with Greater-Than Compare

This block is one up-counting PWM timing unit. A counter climbs from zero to a programmable period value and then wraps. Two compare channels, CMP1 and CMP3, watch the counter. The period event and the compare events together drive a single PWM output. In the default polarity the period event turns the output on and a compare event turns it off. An inverted polarity swaps these roles.

Each compare channel has its own mode bit. In regular mode a channel fires only when the counter equals its active value. New values can be buffered until the counter wraps. In greater-than mode a channel fires on every cycle the counter is at or above its threshold, and a new value goes into the active register at once. Because of this, a compare value written below the running counter still ends the pulse in that same period, with no period lost. Each channel has a sticky status flag. The flag is raised only when the counter reaches the active value by counting, and software clears it by writing a one.

Top module: `pwm_gt_timer`

## Requirements
- R1: While reset is high and in the first cycle after it, `pwm_out`, `cmp1_flag` and `cmp3_flag` are 0 and the counter is 0. Reset values are: period RST_PERIOD, both compares 0, and all control bits 0.
- R2: The register map, with write data taken from `wr_data`, is:
  - address 0: period
  - address 1: CMP1
  - address 2: CMP3
  - address 3: control, with bit0 = CMP1 greater-than, bit1 = CMP3 greater-than, bit2 = preload enable, bit3 = invert polarity
  - address 4: flag clear, with bit0 = CMP1 and bit1 = CMP3

  The counter runs 0..period and wraps to 0. A period write takes effect only when the counter wraps, so the output repeats every period+1 cycles.
- R3: With polarity 0, the cycle where the counter is 0 is the period event, which turns the output on. A compare hit turns it off. Each change appears one cycle after the event, so a regular compare value C gives C high cycles per period.
- R4: In regular mode with preload enabled, a compare write goes into a shadow register and reaches the active register only when the counter wraps.
- R5: In regular mode with preload disabled, a compare write reaches the active register on the next cycle. If the new value is below the counter, no turn-off happens in that period.
- R6: In greater-than mode, a compare write reaches the active register on the next cycle whatever the preload bit is. The channel hits on every cycle with counter >= active value, so a value below the counter turns the output off early.
- R7: A channel's flag is set on the cycle after the counter equals its active value. It stays set until a 1 is written to its bit at address 4; a new set in the same cycle wins over the clear. An early turn-off or a late turn-on caused by a write never sets it.
- R8: If both greater-than bits are set, CMP3 behaves in regular mode.
- R9: When an on event and an off event fall in the same cycle, the output goes off. A regular compare value of 0 therefore keeps the output low for the whole period.
- R10: With polarity 1, a compare hit turns the output on and the period event turns it off. Greater-than mode can then turn the output on late after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | W | Register write data |
| pwm_out | output | 1 | PWM output |
| cmp1_flag | output | 1 | Sticky CMP1 match flag |
| cmp3_flag | output | 1 | Sticky CMP3 match flag |

## Verification
The hardest case to reach is a compare write that lands in the middle of a period with a value the counter has already passed. Whether this turns the output off early, lets it turn on late, or changes nothing depends on the mode, the preload setting and the polarity. It must also never raise a flag. The stimulus follows the bench model's counter and times each such write to a chosen counter value. It then samples the output and the flags a fixed number of cycles later, once for each mode combination.

// File: rtl/pwm_gt_pkg.sv
package pwm_gt_pkg;

    localparam int ADDR_W = 3;
    localparam int NCH    = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_PERIOD  = 3'd0,
        REG_CMP1    = 3'd1,
        REG_CMP3    = 3'd2,
        REG_CTRL    = 3'd3,
        REG_FLAGCLR = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic invert;
        logic preload;
        logic gt3;
        logic gt1;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // greater-than on CMP3 is refused while CMP1 also asks for it
    function automatic logic [NCH-1:0] gt_resolve(input ctrl_t c);
        return {c.gt3 & ~c.gt1, c.gt1};
    endfunction

endpackage

// File: rtl/pwm_gt_counter.sv
module pwm_gt_counter #(
    parameter int W          = 8,
    parameter int RST_PERIOD = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         per_wr,
    input  logic [W-1:0] per_data,
    output logic [W-1:0] cnt,
    output logic         period_evt,
    output logic         rollover
);

    logic [W-1:0] cnt_q, per_sh_q, per_act_q, per_sh_nx;

    assign per_sh_nx  = per_wr ? per_data : per_sh_q;
    assign rollover   = (cnt_q == per_act_q);
    assign period_evt = (cnt_q == '0);
    assign cnt        = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            per_sh_q  <= W'(RST_PERIOD);
            per_act_q <= W'(RST_PERIOD);
        end else begin
            per_sh_q <= per_sh_nx;
            if (rollover) begin
                cnt_q     <= '0;
                per_act_q <= per_sh_nx;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rollover |=> cnt_q == '0);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !rollover |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/pwm_gt_chan.sv
module pwm_gt_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt,
    input  logic         rollover,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         gt_mode,
    input  logic         preload,
    input  logic         clr,
    output logic         hit,
    output logic         flag
);

    logic [W-1:0] sh_q, act_q, sh_nx;
    logic         imm, eq, flag_q;

    assign sh_nx = wr ? wr_data : sh_q;
    assign imm   = gt_mode | ~preload;
    assign eq    = (cnt == act_q);
    assign hit   = gt_mode ? (cnt >= act_q) : eq;
    assign flag  = flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            act_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            sh_q <= sh_nx;
            if (rollover)
                act_q <= sh_nx;
            else if (wr && imm)
                act_q <= wr_data;
            flag_q <= eq | (flag_q & ~clr);
        end
    end

    // R4
    preload_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!gt_mode && preload && !rollover) |=> $stable(act_q));

    // R6
    gt_immediate_chk: assert property (@(posedge clk) disable iff (rst)
        (gt_mode && wr) |=> act_q == $past(wr_data));

    // R7
    flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(eq));

endmodule

// File: rtl/pwm_gt_timer.sv
module pwm_gt_timer
    import pwm_gt_pkg::*;
#(
    parameter int W          = 8,
    parameter int RST_PERIOD = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic              pwm_out,
    output logic              cmp1_flag,
    output logic              cmp3_flag
);

    ctrl_t          ctrl_q;
    logic [NCH-1:0] gt_eff, hit, flag, clr_bits;
    logic [W-1:0]   cnt;
    logic           period_evt, rollover;
    logic           any_hit, on_evt, off_evt, out_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_en && wr_addr == REG_CTRL)
            ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end

    assign gt_eff   = gt_resolve(ctrl_q);
    assign clr_bits = (wr_en && wr_addr == REG_FLAGCLR) ? wr_data[NCH-1:0] : '0;

    pwm_gt_counter #(.W(W), .RST_PERIOD(RST_PERIOD)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .per_wr     (wr_en && wr_addr == REG_PERIOD),
        .per_data   (wr_data),
        .cnt        (cnt),
        .period_evt (period_evt),
        .rollover   (rollover)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam reg_addr_e CH_ADDR = (i == 0) ? REG_CMP1 : REG_CMP3;
        pwm_gt_chan #(.W(W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .cnt      (cnt),
            .rollover (rollover),
            .wr       (wr_en && wr_addr == CH_ADDR),
            .wr_data  (wr_data),
            .gt_mode  (gt_eff[i]),
            .preload  (ctrl_q.preload),
            .clr      (clr_bits[i]),
            .hit      (hit[i]),
            .flag     (flag[i])
        );
    end

    assign any_hit = |hit;
    assign on_evt  = ctrl_q.invert ? any_hit : period_evt;
    assign off_evt = ctrl_q.invert ? period_evt : any_hit;

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= 1'b0;
        else if (off_evt)
            out_q <= 1'b0;
        else if (on_evt)
            out_q <= 1'b1;
    end

    assign pwm_out   = out_q;
    assign cmp1_flag = flag[0];
    assign cmp3_flag = flag[1];

    // R9
    off_priority_chk: assert property (@(posedge clk) disable iff (rst)
        off_evt |=> !out_q);

    // R3
    on_event_chk: assert property (@(posedge clk) disable iff (rst)
        (on_evt && !off_evt) |=> out_q);

    // R10
    invert_period_off_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.invert && period_evt) |=> !out_q);

endmodule

// File: tb/pwm_gt_timer_tb.sv
`timescale 1ns/1ps
module pwm_gt_timer_tb;

    localparam int W = 8;
    localparam int RSTP = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic pwm_out, cmp1_flag, cmp3_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwm_gt_timer #(.W(W), .RST_PERIOD(RSTP)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_out(pwm_out), .cmp1_flag(cmp1_flag), .cmp3_flag(cmp3_flag)
    );

    // behavioural reference
    int m_cnt, m_per, m_per_sh;
    int m_sh[2], m_act[2];
    bit m_flag[2];
    bit m_out, m_gt1, m_gt3, m_pre, m_inv;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_per = RSTP; m_per_sh = RSTP;
            for (int i = 0; i < 2; i++) begin m_sh[i] = 0; m_act[i] = 0; m_flag[i] = 0; end
            m_out = 0; m_gt1 = 0; m_gt3 = 0; m_pre = 0; m_inv = 0;
        end else begin
            bit gte[2];
            bit any, pe, roll, on, off;
            gte[0] = m_gt1;
            gte[1] = m_gt3 && !m_gt1;
            any = 0;
            for (int i = 0; i < 2; i++) begin
                if (gte[i] ? (m_cnt >= m_act[i]) : (m_cnt == m_act[i])) any = 1;
            end
            pe = (m_cnt == 0);
            roll = (m_cnt == m_per);
            on = m_inv ? any : pe;
            off = m_inv ? pe : any;
            if (off) m_out = 0; else if (on) m_out = 1;
            for (int i = 0; i < 2; i++) begin
                bit clr;
                clr = wr_en && wr_addr == 3'd4 && wr_data[i];
                m_flag[i] = (m_cnt == m_act[i]) || (m_flag[i] && !clr);
                if (wr_en && wr_addr == 3'(i + 1)) begin
                    m_sh[i] = int'(wr_data);
                    if (gte[i] || !m_pre) m_act[i] = int'(wr_data);
                end
            end
            if (wr_en && wr_addr == 3'd0) m_per_sh = int'(wr_data);
            if (roll) begin
                m_cnt = 0;
                m_per = m_per_sh;
                for (int i = 0; i < 2; i++) m_act[i] = m_sh[i];
            end else begin
                m_cnt = m_cnt + 1;
            end
            if (wr_en && wr_addr == 3'd3) begin
                m_gt1 = wr_data[0]; m_gt3 = wr_data[1]; m_pre = wr_data[2]; m_inv = wr_data[3];
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R3 pwm_out vs model", int'(pwm_out), int'(m_out));
            check("R7 cmp1_flag vs model", int'(cmp1_flag), int'(m_flag[0]));
            check("R7 cmp3_flag vs model", int'(cmp3_flag), int'(m_flag[1]));
        end
    end

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_cnt(input int k);
        @(negedge clk);
        while (m_cnt != k) @(negedge clk);
    endtask

    task automatic measure(output int hi);
        int n;
        wait_cnt(1);
        n = m_per + 1;
        hi = 0;
        for (int j = 0; j < n; j++) begin
            hi += int'(pwm_out);
            @(negedge clk);
        end
    endtask

    task automatic period_len(output int len);
        bit prev;
        prev = pwm_out;
        @(negedge clk);
        while (!(pwm_out && !prev)) begin prev = pwm_out; @(negedge clk); end
        len = 0;
        prev = pwm_out;
        do begin
            @(negedge clk);
            len++;
            if (pwm_out && !prev) break;
            prev = pwm_out;
        end while (len < 1000);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 out in reset", int'(pwm_out), 0);
        check("R1 cmp1_flag in reset", int'(cmp1_flag), 0);
        check("R1 cmp3_flag in reset", int'(cmp3_flag), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out after reset", int'(pwm_out), 0);

        // regular, preload enabled
        wr(3, 4'b0100); wr(0, 9); wr(1, 4); wr(2, 200);
        wait_cnt(0);
        measure(v);  check("R3 high cycles for CMP1=4", v, 4);
        period_len(v); check("R2 period length", v, 10);

        // R4 buffered write
        wait_cnt(2); wr(1, 1);
        wait_cnt(5); check("R4 old compare still acts", int'(pwm_out), 0);
        measure(v);  check("R4 new compare after wrap", v, 1);

        // R5 preload off
        wr(3, 0); wr(1, 6);
        wait_cnt(0);
        measure(v);  check("R5 immediate compare 6", v, 6);
        wait_cnt(3); wr(1, 2);
        wait_cnt(8); check("R5 passed value misses turn-off", int'(pwm_out), 1);
        measure(v);  check("R5 compare 2 next period", v, 2);

        // R7 flags
        wait_cnt(5); wr(4, 3);
        check("R7 cmp1 flag cleared", int'(cmp1_flag), 0);
        check("R7 cmp3 flag cleared", int'(cmp3_flag), 0);
        wait_cnt(4);
        check("R7 cmp1 flag on equality", int'(cmp1_flag), 1);
        check("R7 cmp3 flag never matched", int'(cmp3_flag), 0);

        // R6 greater-than early turn-off
        wr(3, 4'b0101); wr(1, 7);
        wait_cnt(1); wr(4, 1);
        wait_cnt(3); wr(1, 2);
        wait_cnt(5);
        check("R6 early turn-off", int'(pwm_out), 0);
        check("R7 no flag on early turn-off", int'(cmp1_flag), 0);
        wait_cnt(9);
        check("R7 flag still clear at period end", int'(cmp1_flag), 0);
        measure(v);  check("R6 greater-than compare 2", v, 2);

        // R8 both greater-than bits
        wr(3, 4'b0011); wr(1, 200); wr(2, 8);
        wait_cnt(0);
        measure(v);  check("R8 CMP3 regular width", v, 8);
        wait_cnt(4); wr(2, 1);
        wait_cnt(7); check("R8 CMP3 not greater-than", int'(pwm_out), 1);

        // R9 zero duty
        wr(2, 200); wr(3, 0); wr(1, 0);
        wait_cnt(0);
        measure(v);  check("R9 zero duty", v, 0);

        // R10 inverted polarity
        wr(3, 4'b1000); wr(1, 3);
        wait_cnt(0);
        measure(v);  check("R10 inverted high cycles", v, 7);
        wr(3, 4'b1001); wr(1, 8);
        wait_cnt(1); wr(4, 1);
        wait_cnt(4); wr(1, 2);
        wait_cnt(6);
        check("R10 late turn-on", int'(pwm_out), 1);
        check("R7 no flag on late turn-on", int'(cmp1_flag), 0);

        repeat (3) @(negedge clk);
        summary();
    end

endmodule